// File: doc/BRIEF.md
# Secure Scan Access Mode Controller

This controller sits between the tester and a cryptographic core and decides when the core's scan chain may be used. It has exactly two resting modes, mission and test. In mission mode the scan enable reaching the core is held low and the core sees its secret key. In test mode the tester's scan enable passes through, and the core sees a fixed substitute key, so that nothing shifted out of the chain is derived from the secret.

A mode change is only honoured while the controller rests in one of its two modes and the request names the other mode. Every accepted change, in either direction, first drives the core flip-flop reset low for a fixed number of cycles. It then spends one check cycle reading a multi-bit flag made of sensitive core flip-flops. Those flip-flops settle to one known pattern only after a real reset. A matching flag lets the controller enter the requested mode. Any other value locks it in an alarm state that only power-on reset leaves. Throughout the reset and check cycles, scan stays disabled and the secret key stays hidden.

Top module: `scan_guard_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low) the controller is in mission mode: `test_mode`=0, `alarm`=0, `core_rst_n`=1.
- R2: `scan_en_out` equals `scan_en_in` only while in test mode. In mission mode, during reset, during the check cycle and in alarm, it is 0.
- R3: A request (`req_valid`=1, `req_test`=1 for test, 0 for mission) is accepted only in a resting mode and only when it names the other mode. A request for the current mode, or any request during reset, check or alarm, has no effect.
- R4: An accepted request drives `core_rst_n` low for exactly `RST_CYCLES` cycles (default 8), starting the cycle after the request. This holds for both directions of change.
- R5: `key_out` equals `secret_key` only in mission mode. In every other state it equals the parameter `TEST_KEY`.
- R6: The check cycle follows the reset cycles, with `core_rst_n` high. If `rst_flag` equals `FLAG_OK` (default 4'b1010), the requested mode is entered on the next cycle.
- R7: Any other `rst_flag` value in the check cycle raises `alarm` on the next cycle. Alarm holds `scan_en_out`=0, `test_mode`=0 and `key_out`=`TEST_KEY`, and ignores every request until `rst_n` is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| req_valid | input | 1 | Mode change request strobe |
| req_test | input | 1 | Requested mode: 1 test, 0 mission |
| scan_en_in | input | 1 | Scan enable from the tester |
| secret_key | input | KEY_W | Secret key from key storage |
| rst_flag | input | FLAG_W | Sensitive core flip-flops used as reset evidence |
| scan_en_out | output | 1 | Gated scan enable to the core |
| key_out | output | KEY_W | Key delivered to the core |
| core_rst_n | output | 1 | Core flip-flop reset, active low |
| test_mode | output | 1 | High while resting in test mode |
| alarm | output | 1 | Tamper alarm, sticky until power-on reset |

## Verification
A wrong internal state shows at the ports within one cycle. A state stuck in reset keeps `core_rst_n` low beyond `RST_CYCLES`. A premature mode entry exposes `scan_en_in` or the secret key early. A missed flag comparison lets `test_mode` rise when `alarm` should rise. The bench steps a cycle-level reference model alongside the design and compares all five outputs every cycle. Random requests, scan enables, keys and occasional corrupted flags are mixed with directed sequences for requests during reset, same-mode requests and the locked alarm.

// File: rtl/scg_pkg.sv
package scg_pkg;

  typedef enum logic [2:0] {
    ST_MISSION = 3'd0,
    ST_TEST    = 3'd1,
    ST_FLUSH   = 3'd2,
    ST_VERIFY  = 3'd3,
    ST_ALARM   = 3'd4
  } scg_state_e;

  // last tick of a window of len cycles, counting from zero
  function automatic logic window_last(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

  // a request is a real change only when it names the other resting mode
  function automatic logic is_switch(input logic in_test, input logic want_test);
    return in_test != want_test;
  endfunction

endpackage

// File: rtl/scg_flush_timer.sv
module scg_flush_timer #(
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  import scg_pkg::*;

  localparam int unsigned CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign done = run && window_last(32'(cnt_q), RST_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (!done)   cnt_q <= cnt_q + 1'b1;
  end

  AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (32'(cnt_q) < RST_CYCLES)) else $error("flush counter overran"); // R4

endmodule

// File: rtl/scg_flag_check.sv
module scg_flag_check #(
  parameter int unsigned          FLAG_W  = 4,
  parameter logic [FLAG_W-1:0]    FLAG_OK = 4'b1010
) (
  input  logic [FLAG_W-1:0] flag,
  output logic              good
);
  logic [FLAG_W-1:0] bit_ok;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    assign bit_ok[i] = ~(flag[i] ^ FLAG_OK[i]);
  end

  assign good = &bit_ok;

endmodule

// File: rtl/scg_key_mux.sv
module scg_key_mux #(
  parameter int unsigned       KEY_W    = 128,
  parameter logic [KEY_W-1:0]  TEST_KEY = '0
) (
  input  logic [KEY_W-1:0] secret,
  input  logic             use_secret,
  output logic [KEY_W-1:0] key
);
  assign key = use_secret ? secret : TEST_KEY;
endmodule

// File: rtl/scan_guard_ctrl.sv
module scan_guard_ctrl #(
  parameter int unsigned       KEY_W      = 128,
  parameter int unsigned       FLAG_W     = 4,
  parameter logic [FLAG_W-1:0] FLAG_OK    = 4'b1010,
  parameter int unsigned       RST_CYCLES = 8,
  parameter logic [KEY_W-1:0]  TEST_KEY   = {(KEY_W/8){8'hC3}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_test,
  input  logic              scan_en_in,
  input  logic [KEY_W-1:0]  secret_key,
  input  logic [FLAG_W-1:0] rst_flag,
  output logic              scan_en_out,
  output logic [KEY_W-1:0]  key_out,
  output logic              core_rst_n,
  output logic              test_mode,
  output logic              alarm
);
  import scg_pkg::*;

  scg_state_e state_q, state_d;
  logic       target_test_q;

  // named internal events
  logic resting;
  logic req_hit;
  logic flush_run;
  logic flush_done;
  logic flag_good;
  logic verify_pass;
  logic verify_fail;

  assign resting     = (state_q == ST_MISSION) || (state_q == ST_TEST);
  assign req_hit     = resting && req_valid && is_switch(state_q == ST_TEST, req_test);
  assign flush_run   = (state_q == ST_FLUSH);
  assign verify_pass = (state_q == ST_VERIFY) && flag_good;
  assign verify_fail = (state_q == ST_VERIFY) && !flag_good;

  scg_flush_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (flush_run),
    .done (flush_done)
  );

  scg_flag_check #(.FLAG_W(FLAG_W), .FLAG_OK(FLAG_OK)) u_flag (
    .flag(rst_flag),
    .good(flag_good)
  );

  scg_key_mux #(.KEY_W(KEY_W), .TEST_KEY(TEST_KEY)) u_key (
    .secret    (secret_key),
    .use_secret(state_q == ST_MISSION),
    .key       (key_out)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_MISSION, ST_TEST: if (req_hit) state_d = ST_FLUSH;
      ST_FLUSH:            if (flush_done) state_d = ST_VERIFY;
      ST_VERIFY:           state_d = verify_pass ? (target_test_q ? ST_TEST : ST_MISSION)
                                                 : ST_ALARM;
      ST_ALARM:            state_d = ST_ALARM;
      default:             state_d = ST_ALARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_MISSION;
      target_test_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req_hit) target_test_q <= req_test;
    end
  end

  assign test_mode   = (state_q == ST_TEST);
  assign alarm       = (state_q == ST_ALARM);
  assign core_rst_n  = !flush_run;
  assign scan_en_out = scan_en_in && test_mode;

  AST_SCAN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> !scan_en_out) else $error("scan open outside test"); // R2
  AST_KEY_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_MISSION) |-> (key_out == TEST_KEY)) else $error("secret key exposed"); // R5
  AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> ($past(state_q) == ST_VERIFY && $past(flag_good))) else $error("test entered unverified"); // R3
  AST_VERIFY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VERIFY) |-> ($past(state_q) == ST_FLUSH && core_rst_n)) else $error("check without reset"); // R6
  AST_BAD_FLAG_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    verify_fail |=> alarm) else $error("bad flag not alarmed"); // R7
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> alarm) else $error("alarm released"); // R7
  AST_REQ_STARTS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |=> !core_rst_n) else $error("accepted request without reset"); // R4

endmodule

// File: tb/tb_scan_guard_ctrl.sv
module tb_scan_guard_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int KEY_W      = 128;
  localparam int FLAG_W     = 4;
  localparam logic [FLAG_W-1:0] FLAG_OK = 4'b1010;
  localparam int RST_CYCLES = 8;
  localparam logic [KEY_W-1:0] TEST_KEY = {16{8'hC3}};
  localparam int WATCHDOG   = 100000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_test = 0, scan_en_in = 0;
  logic [KEY_W-1:0] secret_key = '0;
  logic [FLAG_W-1:0] rst_flag = FLAG_OK;
  logic scan_en_out, core_rst_n, test_mode, alarm;
  logic [KEY_W-1:0] key_out;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_guard_ctrl #(.KEY_W(KEY_W), .FLAG_W(FLAG_W), .FLAG_OK(FLAG_OK),
                    .RST_CYCLES(RST_CYCLES), .TEST_KEY(TEST_KEY)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_test(req_test),
    .scan_en_in(scan_en_in), .secret_key(secret_key), .rst_flag(rst_flag),
    .scan_en_out(scan_en_out), .key_out(key_out), .core_rst_n(core_rst_n),
    .test_mode(test_mode), .alarm(alarm));

  // reference model: 0 mission, 1 test, 2 reset, 3 check, 4 alarm
  int m_st = 0, m_cnt = 0;
  bit m_tgt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_tgt <= 0;
    end else begin
      case (m_st)
        0: if (req_valid && req_test)  begin m_st <= 2; m_cnt <= 0; m_tgt <= 1; end
        1: if (req_valid && !req_test) begin m_st <= 2; m_cnt <= 0; m_tgt <= 0; end
        2: if (m_cnt == RST_CYCLES - 1) m_st <= 3; else m_cnt <= m_cnt + 1;
        3: m_st <= (rst_flag == FLAG_OK) ? (m_tgt ? 1 : 0) : 4;
        default: m_st <= 4;
      endcase
    end
  end

  function automatic logic exp_scan(int st, logic sin);
    return (st == 1) && sin;
  endfunction
  function automatic logic [KEY_W-1:0] exp_key(int st, logic [KEY_W-1:0] sk);
    return (st == 0) ? sk : TEST_KEY;
  endfunction

  task automatic chk(string tag, logic [KEY_W-1:0] act, logic [KEY_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 scan_en_out", KEY_W'(scan_en_out), KEY_W'(exp_scan(m_st, scan_en_in)));
    chk("R5 key_out", key_out, exp_key(m_st, secret_key));
    chk("R4 core_rst_n", KEY_W'(core_rst_n), KEY_W'(m_st != 2));
    chk("R1 R3 test_mode", KEY_W'(test_mode), KEY_W'(m_st == 1));
    chk("R6 R7 alarm", KEY_W'(alarm), KEY_W'(m_st == 4));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic por();
    rst_n = 0; req_valid = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  int low_cnt;

  initial begin
    void'($urandom(32'd20240611));
    secret_key = {$urandom, $urandom, $urandom, $urandom};
    por();
    tick();
    chk("R1 reset test_mode", KEY_W'(test_mode), '0);
    chk("R1 reset alarm", KEY_W'(alarm), '0);
    chk("R1 reset core_rst_n", KEY_W'(core_rst_n), KEY_W'(1));

    // same-mode request ignored
    req_valid = 1; req_test = 0; tick(); req_valid = 0;
    chk("R3 same-mode request ignored", KEY_W'(core_rst_n), KEY_W'(1));

    // switch to test; request issued mid-reset must be ignored
    req_valid = 1; req_test = 1; scan_en_in = 1; tick(); req_valid = 0;
    low_cnt = 0;
    while (!core_rst_n && low_cnt < 50) begin
      low_cnt++;
      if (low_cnt == 3) begin req_valid = 1; req_test = 0; end
      else req_valid = 0;
      tick();
    end
    req_valid = 0;
    chk("R4 reset length to test", KEY_W'(low_cnt), KEY_W'(RST_CYCLES));
    chk("R6 check cycle scan off", KEY_W'(scan_en_out), '0);
    tick();
    chk("R3 test reached despite mid-reset request", KEY_W'(test_mode), KEY_W'(1));
    chk("R2 scan passes in test", KEY_W'(scan_en_out), KEY_W'(1));

    // back to mission
    req_valid = 1; req_test = 0; tick(); req_valid = 0;
    low_cnt = 0;
    while (!core_rst_n && low_cnt < 50) begin low_cnt++; tick(); end
    chk("R4 reset length to mission", KEY_W'(low_cnt), KEY_W'(RST_CYCLES));
    tick();
    chk("R5 secret restored in mission", key_out, secret_key);

    // corrupted flag locks alarm
    req_valid = 1; req_test = 1; tick(); req_valid = 0;
    rst_flag = 4'b1011;
    while (!core_rst_n) tick();
    tick();
    chk("R7 alarm on bad flag", KEY_W'(alarm), KEY_W'(1));
    req_valid = 1; req_test = 1; scan_en_in = 1; rst_flag = FLAG_OK;
    repeat (5) tick();
    req_valid = 0;
    chk("R7 alarm sticky", KEY_W'(alarm), KEY_W'(1));
    chk("R7 key hidden in alarm", key_out, TEST_KEY);
    por(); tick();
    chk("R7 alarm cleared by power-on reset", KEY_W'(alarm), '0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      req_valid  = ($urandom_range(0, 5) == 0);
      req_test   = $urandom_range(0, 1);
      scan_en_in = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) secret_key = {$urandom, $urandom, $urandom, $urandom};
      rst_flag = ($urandom_range(0, 19) == 0) ? FLAG_W'($urandom) : FLAG_OK;
      if (alarm && $urandom_range(0, 7) == 0) por();
      tick();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule